// File: doc/BRIEF.md
# Serial Configuration Word Receiver

This block is a serial slave that takes a 23-bit configuration word over three wires (a serial clock, a data line and an enable) and holds the decoded settings for a burst transmitter. The three wires are brought into the system clock domain through a synchronizer. While the enable is high, the block captures one data bit on each falling edge of the serial clock, least significant bit first. When the enable falls, the collected word is judged. It is accepted only if exactly 23 bits arrived and every field lies in its legal range. An accepted word is copied into the output register bank in one step.

The decoded outputs drive the settings of the rest of the transmitter:
- the synthesizer prescaler and feedback divider values,
- bias enable,
- the charge-pump current and three-state options,
- output attenuation,
- shutdown of the digital filter.

A word of the wrong length is dropped without a trace. A full-length word with an illegal field is dropped and raises an error flag. After reset the transmitter stays in a safe, unconfigured state (bias off, filter shut down) until the first accepted word.

The control state machine has three states:
- `ST_IDLE`: waiting for the enable. On enable high it goes to `ST_SHIFT` and the bit counter is cleared.
- `ST_SHIFT`: capturing bits. On enable low it goes to `ST_JUDGE`.
- `ST_JUDGE`: one cycle that issues either a commit, a range rejection, or nothing (length rejection). It always returns to `ST_IDLE`.

Top module: `cfg3w_top`

## Requirements
- R1: While the synchronized enable is high, each falling edge of the serial clock captures one bit. Serial clock edges while the enable is low capture nothing and change no output.
- R2: The first bit received is D0. The outputs are decoded as follows:
  - `pre_a` is D2:D0.
  - `fb_m` is D9:D3.
  - `bias_on` is D10.
  - `cp_high` is D11 (1 selects the higher pump current).
  - `pump_tri_off` is D12 (1 disables three-stating).
  - `atten_db` is D18:D13.
  - D21:D19 are reserved.
  - `dsp_off` is D22.
  - In every field the highest-numbered bit is the MSB.
- R3: A word is committed after the enable falls, and only if exactly 23 bits were captured and the word passes the checks of R6. The outputs change at most 8 system clocks after the enable falls.
- R4: A word with fewer or more than 23 captured bits leaves every setting and `word_err` unchanged.
- R5: The settings change only on a commit.
- R6: A 23-bit word is rejected if any of the following holds:
  - `pre_a` is greater than 5,
  - `fb_m` is below 41 or above 103,
  - `atten_db` is above 40,
  - D21:D19 are not 000.
  A rejected word keeps the previous settings and sets `word_err` to 1.
- R7: `word_err` is cleared by the next committed word.
- R8: After reset the outputs hold the following values until the first commit:
  - `pre_a`, `fb_m`, `atten_db`, `cp_high`, `pump_tri_off` and `bias_on` are 0,
  - `dsp_off` is 1,
  - `unconfigured` is 1,
  - `word_err` is 0.
  `unconfigured` falls on the first commit and stays low.
- R9: A serial clock falling edge that reaches the synchronized domain in the same cycle as the enable falling edge is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data captured on its falling edge |
| ser_dat | input | 1 | Serial data |
| ser_en | input | 1 | Serial enable; high frames a word |
| pre_a | output | 3 | Prescaler value |
| fb_m | output | 7 | Feedback divider value |
| bias_on | output | 1 | Bias networks enable |
| cp_high | output | 1 | Charge-pump higher current select |
| pump_tri_off | output | 1 | Disables three-state on simultaneous up/down |
| atten_db | output | 6 | Attenuation below maximum, in dB |
| dsp_off | output | 1 | Digital filter shutdown |
| unconfigured | output | 1 | High until the first accepted word |
| word_err | output | 1 | Last full-length word had an illegal field |

## Verification
The end of a word and the capture of its last bit can land in the same cycle. This happens when the final serial clock fall and the enable fall are synchronized together. The bench provokes it by dropping `ser_clk` and `ser_en` on the same system clock edge after 23 bits. It then expects the word to count as 22 bits, so the settings and `word_err` must stay unchanged. A control run with the edges separated must commit the same word.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    localparam int CFG_BITS = 23;

    // field positions: decoded by the transmitter, so fixed
    localparam int A_LSB   = 0;
    localparam int A_W     = 3;
    localparam int M_LSB   = 3;
    localparam int M_W     = 7;
    localparam int BIAS_B  = 10;
    localparam int CPH_B   = 11;
    localparam int TRI_B   = 12;
    localparam int ATT_LSB = 13;
    localparam int ATT_W   = 6;
    localparam int RSV_LSB = 19;
    localparam int RSV_W   = 3;
    localparam int DSP_B   = 22;

    typedef struct packed {
        logic [A_W-1:0]   pre_a;
        logic [M_W-1:0]   fb_m;
        logic             bias_on;
        logic             cp_high;
        logic             tri_off;
        logic [ATT_W-1:0] atten;
        logic             dsp_off;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_JUDGE = 2'd2
    } rx_state_t;

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/cfg3w_decode.sv
module cfg3w_decode
    import cfg3w_pkg::*;
#(
    parameter int A_MAX   = 5,
    parameter int M_MIN   = 41,
    parameter int M_MAX   = 103,
    parameter int ATT_MAX = 40
) (
    input  logic [CFG_BITS-1:0] word,
    output cfg_t                fields,
    output logic                legal
);
    logic [RSV_W-1:0] rsv;

    always_comb begin
        fields.pre_a   = word[A_LSB +: A_W];
        fields.fb_m    = word[M_LSB +: M_W];
        fields.bias_on = word[BIAS_B];
        fields.cp_high = word[CPH_B];
        fields.tri_off = word[TRI_B];
        fields.atten   = word[ATT_LSB +: ATT_W];
        fields.dsp_off = word[DSP_B];
        rsv            = word[RSV_LSB +: RSV_W];
        legal = (int'(fields.pre_a) <= A_MAX)
             && (int'(fields.fb_m)  >= M_MIN)
             && (int'(fields.fb_m)  <= M_MAX)
             && (int'(fields.atten) <= ATT_MAX)
             && (rsv == '0);
    end
endmodule

// File: rtl/cfg3w_rx_fsm.sv
module cfg3w_rx_fsm
    import cfg3w_pkg::*;
#(
    parameter int WORD_BITS = CFG_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_s,
    input  logic                 sdat_s,
    input  logic                 sen_s,
    input  logic                 legal,
    output logic [WORD_BITS-1:0] shreg,
    output logic                 commit,
    output logic                 reject
);
    localparam int CNT_MAX = WORD_BITS + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    rx_state_t        state, state_nx;
    logic             sclk_d;
    logic             fall;
    logic [CNT_W-1:0] cnt;
    logic             full;

    assign fall = sclk_d & ~sclk_s;
    assign full = (cnt == CNT_W'(WORD_BITS));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (sen_s)  state_nx = ST_SHIFT;
            ST_SHIFT: if (!sen_s) state_nx = ST_JUDGE;
            ST_JUDGE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath: edge history, counter, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (state == ST_IDLE && sen_s) begin
                cnt <= '0;
            end else if (state == ST_SHIFT && sen_s && fall) begin
                shreg <= {sdat_s, shreg[WORD_BITS-1:1]};
                if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs of the state machine
    always_comb begin
        commit = 1'b0;
        reject = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_SHIFT: ;
            ST_JUDGE: begin
                commit = full & legal;
                reject = full & ~legal;
            end
            default:  ;
        endcase
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(CNT_MAX)); // R4
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit, reject})); // R3
    AST_IDLE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !sen_s) |=> $stable(shreg)); // R1
endmodule

// File: rtl/cfg3w_top.sv
module cfg3w_top
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int A_MAX       = 5,
    parameter int M_MIN       = 41,
    parameter int M_MAX       = 103,
    parameter int ATT_MAX     = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_en,
    output logic [A_W-1:0]   pre_a,
    output logic [M_W-1:0]   fb_m,
    output logic             bias_on,
    output logic             cp_high,
    output logic             pump_tri_off,
    output logic [ATT_W-1:0] atten_db,
    output logic             dsp_off,
    output logic             unconfigured,
    output logic             word_err
);
    localparam int   IN_W    = 3;
    localparam cfg_t CFG_RST = '{pre_a: '0, fb_m: '0, bias_on: 1'b0,
                                 cp_high: 1'b0, tri_off: 1'b0,
                                 atten: '0, dsp_off: 1'b1};

    logic [IN_W-1:0]     sync_q;
    logic [CFG_BITS-1:0] shreg;
    cfg_t                dec, cfg_q;
    logic                legal, commit, reject;

    cfg3w_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({ser_en, ser_dat, ser_clk}), .dout(sync_q)
    );

    cfg3w_rx_fsm #(.WORD_BITS(CFG_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(sync_q[0]), .sdat_s(sync_q[1]), .sen_s(sync_q[2]),
        .legal(legal), .shreg(shreg), .commit(commit), .reject(reject)
    );

    cfg3w_decode #(.A_MAX(A_MAX), .M_MIN(M_MIN), .M_MAX(M_MAX),
                   .ATT_MAX(ATT_MAX)) u_dec (
        .word(shreg), .fields(dec), .legal(legal)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= CFG_RST;
            unconfigured <= 1'b1;
            word_err     <= 1'b0;
        end else if (commit) begin
            cfg_q        <= dec;
            unconfigured <= 1'b0;
            word_err     <= 1'b0;
        end else if (reject) begin
            word_err     <= 1'b1;
        end
    end

    assign pre_a        = cfg_q.pre_a;
    assign fb_m         = cfg_q.fb_m;
    assign bias_on      = cfg_q.bias_on;
    assign cp_high      = cfg_q.cp_high;
    assign pump_tri_off = cfg_q.tri_off;
    assign atten_db     = cfg_q.atten;
    assign dsp_off      = cfg_q.dsp_off;

    AST_SAFE_UNCONFIG: assert property (@(posedge clk) disable iff (!rst_n)
        unconfigured |-> (dsp_off && !bias_on)); // R8
    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg_q)); // R5
    AST_COMMIT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (int'(pre_a) <= A_MAX && int'(fb_m) >= M_MIN
                    && int'(fb_m) <= M_MAX && int'(atten_db) <= ATT_MAX)); // R6
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !word_err); // R7
    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> word_err); // R6
endmodule

// File: tb/tb_cfg3w_top.sv
module tb_cfg3w_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
    logic [2:0] pre_a;
    logic [6:0] fb_m;
    logic bias_on, cp_high, pump_tri_off, dsp_off, unconfigured, word_err;
    logic [5:0] atten_db;

    int checks = 0;
    int errors = 0;
    logic [22:0] exp_w;   // expected settings as a word image
    logic exp_unc, exp_err;

    always #2 clk = ~clk;

    cfg3w_top dut (.*);

    function automatic logic word_legal(input logic [22:0] w);
        return (w[2:0] <= 3'd5) && (w[9:3] >= 7'd41) && (w[9:3] <= 7'd103)
            && (w[18:13] <= 6'd40) && (w[21:19] == 3'd0);
    endfunction

    function automatic logic [22:0] make_word(input int a, input int m,
                                              input int att, input int rsv,
                                              input logic [3:0] flags);
        logic [22:0] w;
        w = '0;
        w[2:0]   = a[2:0];
        w[9:3]   = m[6:0];
        w[10]    = flags[0];
        w[11]    = flags[1];
        w[12]    = flags[2];
        w[18:13] = att[5:0];
        w[21:19] = rsv[2:0];
        w[22]    = flags[3];
        return w;
    endfunction

    task automatic check_all(input string req);
        logic [22:0] act;
        logic [22:0] expm;
        act  = make_word(int'(pre_a), int'(fb_m), int'(atten_db), 0,
                         {dsp_off, pump_tri_off, cp_high, bias_on});
        expm = exp_w;
        expm[21:19] = 3'd0;
        checks++;
        if (act !== expm || unconfigured !== exp_unc || word_err !== exp_err) begin
            errors++;
            $display("FAIL %s: act word=%h unc=%b err=%b exp word=%h unc=%b err=%b",
                     req, act, unconfigured, word_err, expm, exp_unc, exp_err);
        end
    endtask

    // n bits sent; coinc drops clock and enable together on the last bit
    task automatic send(input logic [31:0] w, input int n, input logic coinc);
        int eff;
        @(negedge clk); ser_en = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            ser_clk = 1'b1; ser_dat = w[i];
            repeat (6) @(negedge clk);
            if (coinc && i == n - 1) ser_en = 1'b0;
            ser_clk = 1'b0;
            repeat (6) @(negedge clk);
        end
        ser_en = 1'b0;
        repeat (12) @(negedge clk);
        eff = coinc ? n - 1 : n;
        if (eff == 23) begin
            if (word_legal(w[22:0])) begin
                exp_w = w[22:0]; exp_unc = 1'b0; exp_err = 1'b0;
            end else begin
                exp_err = 1'b1;
            end
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: act=expired exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [22:0] good;
        void'($urandom(32'd4711));
        exp_w = make_word(0, 0, 0, 0, 4'b1000); exp_unc = 1'b1; exp_err = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R8 reset defaults");

        // clock pulses with enable low
        for (int i = 0; i < 30; i++) begin
            ser_clk = 1'b1; ser_dat = 1'b1; repeat (4) @(negedge clk);
            ser_clk = 1'b0; repeat (4) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        check_all("R1 edges ignored with enable low");

        good = make_word(5, 103, 40, 0, 4'b0101);
        send({9'd0, good}, 23, 1'b0);
        check_all("R2 R3 field map, upper limits accepted");
        send({9'd0, make_word(0, 41, 0, 0, 4'b1010)}, 23, 1'b0);
        check_all("R3 lower limits accepted");
        send({9'd0, make_word(1, 60, 3, 0, 4'b0111)}, 22, 1'b0);
        check_all("R4 short word dropped");
        send({9'h1AB, make_word(2, 70, 5, 0, 4'b0001)}, 24, 1'b0);
        check_all("R4 long word dropped");
        send({9'd0, make_word(6, 60, 0, 0, 4'b0001)}, 23, 1'b0);
        check_all("R6 A=6 rejected");
        send({9'd0, make_word(3, 60, 0, 0, 4'b0001)}, 23, 1'b0);
        check_all("R7 error cleared by commit");
        send({9'd0, make_word(3, 40, 0, 0, 4'b0001)}, 23, 1'b0);
        check_all("R6 M=40 rejected");
        send({9'd0, make_word(3, 104, 0, 0, 4'b0001)}, 23, 1'b0);
        check_all("R6 M=104 rejected");
        send({9'd0, make_word(3, 50, 41, 0, 4'b0001)}, 23, 1'b0);
        check_all("R6 atten=41 rejected");
        send({9'd0, make_word(3, 50, 2, 4, 4'b0001)}, 23, 1'b0);
        check_all("R6 reserved nonzero rejected");
        send({9'd0, make_word(1, 55, 7, 0, 4'b1110)}, 23, 1'b1);
        check_all("R9 coincident last edge not captured");
        send({9'd0, make_word(1, 55, 7, 0, 4'b1110)}, 23, 1'b0);
        check_all("R9 control, separated edges commit");
        repeat (20) @(negedge clk);
        check_all("R5 settings stable while idle");

        for (int k = 0; k < 40; k++) begin
            logic [22:0] w;
            int n;
            w = make_word(int'($urandom_range(0, 7)),
                          ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 127))
                                                      : int'($urandom_range(41, 103)),
                          ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 63))
                                                      : int'($urandom_range(0, 40)),
                          ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 7)) : 0,
                          4'($urandom));
            n = ($urandom_range(0, 5) == 0) ? int'($urandom_range(20, 26)) : 23;
            send({9'($urandom), w}, n, 1'b0);
            check_all("R2 R3 R4 R6 random word");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule